// File: doc/BRIEF.md
# Second-Order Single-Bit Noise-Shaping Modulator

This block sits between an oversampling interpolation stage and a one-bit output DAC. It takes signed multi-bit samples and turns them into a single-bit stream whose running average follows the input level. The loop has two cascaded accumulators, each with one register of delay. A one-bit quantizer reads the second accumulator. Its decision is mapped to plus or minus full scale and subtracted at the input of both accumulators, which pushes the quantization error out towards high frequencies.

Samples arrive on a valid/ready stream. The block holds the last accepted sample and uses it on every modulator step until a new one is accepted. `in_ready` is high whenever the block is out of reset, so the block never applies back-pressure to the sample producer. The output is also a valid/ready stream. `out_valid` is high every cycle out of reset. The loop advances one step, and presents the next bit, only in a cycle where `out_ready` is high. A consumer that holds `out_ready` low freezes the whole loop. No step is lost, and no step is repeated. With a 2.048 MHz modulator clock and samples held for 256 clocks, this gives 8 kHz audio at the oversampling ratio the DAC expects. Both accumulators saturate and never wrap.

Top module: `dsm2_modulator`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_bit`, `out_valid` and `in_ready` are low after that edge. Both accumulators and the held sample are cleared, so a run after reset does not depend on any earlier run.
- R2: `in_ready` is high in every cycle out of reset. A sample is accepted at an edge where `in_valid` and `in_ready` are both high. It replaces the previously held sample and is used by every later step.
- R3: `in_data` has no effect while `in_valid` is low.
- R4: `out_valid` is high in every cycle out of reset. The loop takes exactly one step per edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_bit` and the loop state hold.
- R5: `in_data` is a 13-bit two's-complement value x, with full scale FS = 4096. Bit value 1 stands for +FS in the feedback path and 0 stands for −FS. Start from reset, hold x constant and take 4096 transfers. For |x| ≤ 2048, the number of ones is within ±4 of (x + 4096)/2.
- R6: The accumulators saturate rather than wrap. For x = +4095 the ones count over 4096 transfers is within ±12 of 4095. For x = −4096 it is within ±12 of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample on `in_data` is offered |
| in_ready | output | 1 | Block accepts a sample (high out of reset) |
| in_data | input | 13 | Signed two's-complement sample |
| out_valid | output | 1 | `out_bit` holds a bit for the consumer |
| out_ready | input | 1 | Consumer takes `out_bit`; the loop steps |
| out_bit | output | 1 | Modulated bit, 1 = +FS, 0 = −FS |

## Verification
The modulator is driven with constant levels: zero, mid-range values of both signs, exactly half scale, and the two full-scale extremes. Random levels within half scale are added from a fixed seed. The ones density over 4096 transfers tells a correct loop apart from a wrong feedback sign, a wrong stage order and a stalled loop. The extremes tell saturating accumulators apart from wrapping ones. `out_ready` is pulled low at random, which shows that stalls neither lose nor repeat a step and that the bit holds during a stall. Further runs confirm that junk on `in_data` with `in_valid` low is ignored. They also confirm that a second accepted sample replaces the first, and that reset after a saturated run restores a clean start.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  // Number of cascaded accumulator stages (noise-shaping order).
  localparam int STAGES = 2;

  // Accumulator width of stage k: input width plus guard bits that grow per stage.
  function automatic int acc_width(input int data_w, input int guard, input int step, input int k);
    return data_w + guard + k * step;
  endfunction

endpackage

// File: rtl/dsm_sample_hold.sv
module dsm_sample_hold #(
  parameter int DATA_W = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     in_ready,
  output logic signed [DATA_W-1:0] held
);

  logic ready_q;
  logic signed [DATA_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      held_q  <= '0;
    end else begin
      ready_q <= 1'b1;
      if (in_valid && ready_q) held_q <= in_data;
    end
  end

  assign in_ready = ready_q;
  assign held     = held_q;

  // R2: an accepted sample becomes the held value
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (held == $past(in_data)));

  // R3: without in_valid the held value does not move
  assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> $stable(held));

endmodule

// File: rtl/dsm_integrator.sv
module dsm_integrator #(
  parameter int W_ADD  = 18,
  parameter int W_ACC  = 16,
  parameter int FB_MAG = 4096
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [W_ADD-1:0] addend,
  input  logic                    fb,
  output logic signed [W_ACC-1:0] acc_next
);

  localparam int WS = ((W_ADD > W_ACC) ? W_ADD : W_ACC) + 2;
  localparam logic signed [WS-1:0] ACC_MAX = WS'((64'sd1 <<< (W_ACC - 1)) - 64'sd1);
  localparam logic signed [WS-1:0] ACC_MIN = -ACC_MAX - WS'(1);
  localparam logic signed [WS-1:0] FB_POS  = WS'(FB_MAG);
  localparam logic signed [WS-1:0] FB_NEG  = -FB_POS;

  logic signed [W_ACC-1:0] acc_q;
  logic signed [WS-1:0]    ext_acc;
  logic signed [WS-1:0]    ext_add;
  logic signed [WS-1:0]    fb_val;
  logic signed [WS-1:0]    delta;
  logic signed [WS-1:0]    sum;
  logic signed [WS-1:0]    clamped;

  always_comb begin
    ext_acc = WS'(acc_q);
    ext_add = WS'(addend);
    fb_val  = fb ? FB_POS : FB_NEG;
    delta   = ext_add - fb_val;
    sum     = ext_acc + delta;
    if (sum > ACC_MAX)      clamped = ACC_MAX;
    else if (sum < ACC_MIN) clamped = ACC_MIN;
    else                    clamped = sum;
  end

  assign acc_next = clamped[W_ACC-1:0];

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_next;
  end

  // R6: a non-negative state plus a non-negative change never turns negative
  assert_no_wrap_pos_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !acc_q[W_ACC-1] && !delta[WS-1]) |=> !acc_q[W_ACC-1]);

  // R6: a negative state plus a negative change never turns non-negative
  assert_no_wrap_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (en && acc_q[W_ACC-1] && delta[WS-1]) |=> acc_q[W_ACC-1]);

  // R4: the state is frozen while the loop does not step
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(acc_q));

  // R1: reset clears the accumulator
  assert_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0));

endmodule

// File: rtl/dsm_quantizer.sv
module dsm_quantizer #(
  parameter int W_LVL = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [W_LVL-1:0] level,
  output logic                    bit_q
);

  always_ff @(posedge clk) begin
    if (rst)     bit_q <= 1'b0;
    else if (en) bit_q <= ~level[W_LVL-1];
  end

  // R1: reset forces the output bit low
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !bit_q);

  // R4: the bit holds while the loop is stalled
  assert_bit_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(bit_q));

endmodule

// File: rtl/dsm2_modulator.sv
module dsm2_modulator
  import dsm_pkg::*;
#(
  parameter int DATA_W     = 13,
  parameter int GUARD      = 3,
  parameter int GUARD_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit
);

  localparam int FB_MAG = 1 << (DATA_W - 1);
  localparam int W_TOP  = acc_width(DATA_W, GUARD, GUARD_STEP, STAGES - 1);

  logic signed [DATA_W-1:0] held;
  logic                     valid_q;
  logic                     step;
  logic                     fb_bit;
  logic signed [W_TOP-1:0]  stage_add [STAGES];
  logic signed [W_TOP-1:0]  stage_nx  [STAGES];

  dsm_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .held     (held)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= 1'b1;
  end

  assign out_valid = valid_q;
  assign step      = valid_q & out_ready;

  // First stage integrates the held sample; each later stage integrates
  // the freshly updated value of the stage before it.
  assign stage_add[0] = W_TOP'(held);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int W_ACC = acc_width(DATA_W, GUARD, GUARD_STEP, k);
    logic signed [W_ACC-1:0] nx_k;

    dsm_integrator #(
      .W_ADD  (W_TOP),
      .W_ACC  (W_ACC),
      .FB_MAG (FB_MAG)
    ) u_int (
      .clk      (clk),
      .rst      (rst),
      .en       (step),
      .addend   (stage_add[k]),
      .fb       (fb_bit),
      .acc_next (nx_k)
    );

    assign stage_nx[k] = W_TOP'(nx_k);
    if (k + 1 < STAGES) begin : g_chain
      assign stage_add[k+1] = stage_nx[k];
    end
  end

  dsm_quantizer #(.W_LVL(W_TOP)) u_quant (
    .clk   (clk),
    .rst   (rst),
    .en    (step),
    .level (stage_nx[STAGES-1]),
    .bit_q (fb_bit)
  );

  assign out_bit = fb_bit;

  // R4: out_valid is up in every cycle after reset
  assert_valid_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid);

  // R1: reset drops both stream handshakes
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready));

endmodule

// File: tb/dsm2_modulator_bench.sv
module dsm2_modulator_bench;

  localparam int DW = 13;
  localparam int N_XFER = 4096;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic          out_bit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dsm2_modulator u_dsm2_modulator (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit)
  );

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int expected_ones(input int x);
    return (x + 4096) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input int x);
    in_valid = 1'b1;
    in_data  = DW'(x);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Counts ones over N_XFER transfers with random stalls and junk on in_data.
  task automatic measure(output int ones, output int stall_err);
    int n = 0;
    bit stalled = 1'b0;
    bit stall_bit = 1'b0;
    ones = 0; stall_err = 0;
    while (n < N_XFER) begin
      bit rdy;
      if (stalled && out_bit != stall_bit) stall_err++;
      rdy = ($urandom % 4) != 0;
      out_ready = rdy;
      in_data   = DW'($urandom);
      if (rdy) begin
        ones += int'(out_bit);
        n++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        stall_bit = out_bit;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic run_level(input int x, input int tol, input string req);
    int ones, serr, exp;
    load(x);
    measure(ones, serr);
    exp = expected_ones(x);
    check((ones >= exp - tol) && (ones <= exp + tol), req, ones, exp);
    check(serr == 0, "R4 stall hold", serr, 0);
  endtask

  initial begin
    process::self().srandom(32'h5eed_1234);

    // R1: state during reset
    repeat (3) @(negedge clk);
    check(out_bit == 1'b0,   "R1 out_bit in reset",   int'(out_bit),   0);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b0,  "R1 in_ready in reset",  int'(in_ready),  0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1,  "R2 in_ready after reset",  int'(in_ready),  1);
    check(out_valid == 1'b1, "R4 out_valid after reset", int'(out_valid), 1);

    // R5: directed mid-range levels
    run_level(0, 4, "R5 level 0");
    apply_reset(); run_level(1000, 4, "R5 level 1000");
    apply_reset(); run_level(-1500, 4, "R5 level -1500");
    apply_reset(); run_level(2048, 4, "R5 level 2048");
    apply_reset(); run_level(-2048, 4, "R5 level -2048");

    // R6: full-scale extremes rely on saturation
    apply_reset(); run_level(4095, 12, "R6 level +4095");
    apply_reset(); run_level(-4096, 12, "R6 level -4096");

    // R1: reset after a saturated run restores a clean start
    apply_reset(); run_level(0, 4, "R1 clean restart");

    // R2: second accepted sample replaces the first
    apply_reset();
    in_valid = 1'b1; in_data = DW'(1800); @(negedge clk);
    run_level(-1000, 4, "R2 replace sample");

    // R3: junk on in_data with in_valid low (measure drives it every cycle)
    apply_reset(); run_level(1500, 4, "R3 ignore in_data");

    // R5: random levels within half scale
    for (int i = 0; i < 6; i++) begin
      int x;
      x = int'($urandom % 4097) - 2048;
      apply_reset();
      run_level(x, 4, "R5 random level");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule